// File: doc/BRIEF.md
# SMRAM Window Remapper

This block decides, for every host memory address, whether the access lands in the system-management RAM window. It also produces the physical DRAM address that the access should use. A control byte sets everything. One bit turns the feature on. A three-bit mode field picks the window layout and how the window behaves outside SMM. A further bit selects an alternate window type, which is reported on its own output. The SMM-active signal from the processor side says whether the current access comes from system-management code.

There are three layouts. In the first, a 64 KB window at 0xD0000 is redirected to DRAM at 0xB0000. In the second, the 128 KB region from 0xA0000 to 0xBFFFF is passed straight through to the DRAM behind it. In the third, a 64 KB window at 0x30000 is redirected to DRAM at 0xB0000. Each layout has an even mode number and an odd mode number. With the even mode, the window exists only while SMM is active. With the odd mode, the window is also open to ordinary accesses.

All outputs are registered. Each output shows the decision for the inputs sampled at the previous rising clock edge.

Top module: `smram_remap`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `hit` = 0, `alt_type` = 0 and `dram_addr` = 0.
- R2: When `ctrl[0]` (enable) is 0, `hit` = 0 and `alt_type` = 0, whatever the mode and address are. `dram_addr` equals the host address.
- R3: Mode 0 or 1 (`ctrl[3:1]`): host addresses 0xD0000 to 0xDFFFF give a hit. The DRAM address is 0xB0000 plus the offset within the window.
- R4: Mode 2 or 3: host addresses 0xA0000 to 0xBFFFF give a hit. The DRAM address equals the host address.
- R5: Mode 4 or 5: host addresses 0x30000 to 0x3FFFF give a hit. The DRAM address is 0xB0000 plus the offset within the window.
- R6: In an even mode, an in-window address gives a hit only when `smm_active` = 1. In an odd mode, it gives a hit regardless of `smm_active`.
- R7: `alt_type` = `ctrl[4]` when the block is enabled and the mode is 2 or 3. In every other case, `alt_type` = 0.
- R8: Mode 6 or 7 behaves as disabled: `hit` = 0, `alt_type` = 0, and the address passes through.
- R9: Whenever `hit` = 0, `dram_addr` equals the host address sampled on the same edge. This includes addresses just outside a window.
- R10: The outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 8 | Control byte: bit 0 enable, bits 3:1 mode, bit 4 alternate type |
| smm_active | input | 1 | High while the processor is in system-management mode |
| host_addr | input | 20 | Host memory address |
| hit | output | 1 | The access falls in an open SMRAM window |
| dram_addr | output | 20 | Translated DRAM address, or the host address on a miss |
| alt_type | output | 1 | Alternate window type selected |

## Verification
Each of the six modes is tried with:
- an address inside its window;
- the first and last address of the window;
- the addresses just below and just above the window.

These tell a correct window edge from an off-by-one edge, and a redirected address from a passed-through one. Each in-window address is applied with `smm_active` both high and low. This separates the even modes, which need SMM, from the odd modes, which do not.

Four further patterns isolate the cases where the window must stay closed:
- the enable bit cleared;
- mode values 6 and 7;
- the alternate-type bit toggled in modes where it must be ignored;
- an address that lies in another layout's window.

// File: rtl/smram_remap.sv
module smram_remap #(
  parameter int          AW        = 20,
  parameter logic [19:0] HI_BASE   = 20'hD0000,
  parameter logic [19:0] LO_BASE   = 20'h30000,
  parameter logic [19:0] LEG_BASE  = 20'hA0000,
  parameter logic [19:0] DRAM_BASE = 20'hB0000,
  parameter int          SMALL_W   = 16,
  parameter int          LEG_W     = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ctrl,
  input  logic          smm_active,
  input  logic [AW-1:0] host_addr,
  output logic          hit,
  output logic [AW-1:0] dram_addr,
  output logic          alt_type
);
  localparam int SMALL_TAG = AW - SMALL_W;
  localparam int LEG_TAG   = AW - LEG_W;

  logic [2:0]    mode;
  logic          en, legacy_mode, relocate_mode, open_now;
  logic          in_hi, in_lo, in_leg, in_win;
  logic          hit_d, alt_d;
  logic [AW-1:0] reloc_addr, addr_d;

  assign en            = ctrl[0];
  assign mode          = ctrl[3:1];
  assign legacy_mode   = en && (mode[2:1] == 2'b01);
  assign relocate_mode = en && (mode[2:1] == 2'b00 || mode[2:1] == 2'b10);
  assign open_now      = smm_active || mode[0];

  assign in_hi  = host_addr[AW-1 -: SMALL_TAG] == HI_BASE[AW-1 -: SMALL_TAG];
  assign in_lo  = host_addr[AW-1 -: SMALL_TAG] == LO_BASE[AW-1 -: SMALL_TAG];
  assign in_leg = host_addr[AW-1 -: LEG_TAG]   == LEG_BASE[AW-1 -: LEG_TAG];

  always_comb begin
    in_win = 1'b0;
    unique case (mode[2:1])
      2'b00:   in_win = relocate_mode && in_hi;
      2'b01:   in_win = legacy_mode && in_leg;
      2'b10:   in_win = relocate_mode && in_lo;
      default: in_win = 1'b0;
    endcase
  end

  assign reloc_addr = {DRAM_BASE[AW-1 -: SMALL_TAG], host_addr[SMALL_W-1:0]};
  assign hit_d      = in_win && open_now;
  assign addr_d     = (hit_d && relocate_mode) ? reloc_addr : host_addr;
  assign alt_d      = legacy_mode && ctrl[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      dram_addr <= '0;
      alt_type  <= 1'b0;
    end else begin
      hit       <= hit_d;
      dram_addr <= addr_d;
      alt_type  <= alt_d;
    end
  end
endmodule

module smram_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ctrl,
  input logic        smm_active,
  input logic [19:0] host_addr,
  input logic        hit,
  input logic [19:0] dram_addr,
  input logic        alt_type
);
  logic primed;
  always_ff @(posedge clk) primed <= rst_n;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!hit && !alt_type && dram_addr == 20'h0)); // R1
  AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(ctrl[0])) |-> (!hit && !alt_type)); // R2
  AST_HIT_LANDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (dram_addr[19:17] == 3'b101)); // R3
  AST_EVEN_NEEDS_SMM: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && hit && !$past(ctrl[1])) |-> $past(smm_active)); // R6
  AST_ALT_ONLY_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && alt_type) |-> ($past(ctrl[3:2]) == 2'b01 && $past(ctrl[0]))); // R7
  AST_MODE_HIGH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(ctrl[3:2]) == 2'b11) |-> !hit); // R8
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !hit) |-> dram_addr == $past(host_addr)); // R9
endmodule

bind smram_remap smram_remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .smm_active(smm_active),
  .host_addr(host_addr), .hit(hit), .dram_addr(dram_addr), .alt_type(alt_type)
);

// File: tb/smram_remap_tb.sv
module smram_remap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctrl = 8'h00;
  logic        smm_active = 1'b0;
  logic [19:0] host_addr = 20'h0;
  logic        hit, alt_type;
  logic [19:0] dram_addr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  smram_remap u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .smm_active(smm_active),
    .host_addr(host_addr), .hit(hit), .dram_addr(dram_addr), .alt_type(alt_type)
  );

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic h, input logic [19:0] a,
                       input logic t);
    checks++;
    if (hit !== h || dram_addr !== a || alt_type !== t) begin
      errors++;
      $display("FAIL %s: got hit=%0b addr=%05h alt=%0b expected hit=%0b addr=%05h alt=%0b",
               req, hit, dram_addr, alt_type, h, a, t);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic s, input logic [19:0] a);
    @(negedge clk);
    ctrl = c; smm_active = s; host_addr = a;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] cb(input int m, input logic alt);
    return {3'b000, alt, m[2:0], 1'b1};
  endfunction

  task automatic t_reset;
    check("R1", 1'b0, 20'h0, 1'b0);
  endtask

  task automatic t_disabled;
    apply(8'h12 & 8'hFE, 1'b1, 20'hA1234);
    check("R2", 1'b0, 20'hA1234, 1'b0);
    apply(8'h00, 1'b1, 20'hD0010);
    check("R2", 1'b0, 20'hD0010, 1'b0);
  endtask

  task automatic t_relocated(input int m, input logic [19:0] base, input string req);
    apply(cb(m, 1'b0), 1'b1, base);
    check(req, 1'b1, 20'hB0000, 1'b0);
    apply(cb(m, 1'b0), 1'b1, base | 20'h0FFFF);
    check(req, 1'b1, 20'hBFFFF, 1'b0);
    apply(cb(m, 1'b1), 1'b1, base | 20'h04567);
    check({req, "/R7"}, 1'b1, 20'hB4567, 1'b0);
    apply(cb(m, 1'b0), 1'b1, base - 20'h1);
    check({req, "/R9"}, 1'b0, base - 20'h1, 1'b0);
    apply(cb(m, 1'b0), 1'b1, base + 20'h10000);
    check({req, "/R9"}, 1'b0, base + 20'h10000, 1'b0);
    apply(cb(m, 1'b0), 1'b1, 20'hA8000);
    check({req, "/R9"}, 1'b0, 20'hA8000, 1'b0);
    apply(cb(m, 1'b0), 1'b0, base | 20'h00100);
    check({req, "/R6"}, m[0], m[0] ? 20'hB0100 : (base | 20'h00100), 1'b0);
  endtask

  task automatic t_legacy(input int m);
    apply(cb(m, 1'b0), 1'b1, 20'hA0000);
    check("R4", 1'b1, 20'hA0000, 1'b0);
    apply(cb(m, 1'b1), 1'b1, 20'hBFFFF);
    check("R4/R7", 1'b1, 20'hBFFFF, 1'b1);
    apply(cb(m, 1'b1), 1'b1, 20'h9FFFF);
    check("R9/R7", 1'b0, 20'h9FFFF, 1'b1);
    apply(cb(m, 1'b0), 1'b1, 20'hC0000);
    check("R9", 1'b0, 20'hC0000, 1'b0);
    apply(cb(m, 1'b0), 1'b1, 20'hD0000);
    check("R9", 1'b0, 20'hD0000, 1'b0);
    apply(cb(m, 1'b0), 1'b0, 20'hA5555);
    check("R6", m[0], 20'hA5555, 1'b0);
  endtask

  task automatic t_high_modes;
    for (int m = 6; m < 8; m++) begin
      apply(cb(m, 1'b1), 1'b1, 20'hA0000);
      check("R8", 1'b0, 20'hA0000, 1'b0);
      apply(cb(m, 1'b1), 1'b1, 20'hD0000);
      check("R8", 1'b0, 20'hD0000, 1'b0);
      apply(cb(m, 1'b1), 1'b1, 20'h30000);
      check("R8", 1'b0, 20'h30000, 1'b0);
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    ctrl = cb(3, 1'b1); smm_active = 1'b0; host_addr = 20'hB0001;
    @(posedge clk);
    #2;
    ctrl = 8'h00; host_addr = 20'h12345;
    #5;
    check("R10", 1'b1, 20'hB0001, 1'b1);
    @(posedge clk);
    #2;
    check("R10", 1'b0, 20'h12345, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_disabled();
    t_relocated(0, 20'hD0000, "R3");
    t_relocated(1, 20'hD0000, "R3");
    t_legacy(2);
    t_legacy(3);
    t_relocated(4, 20'h30000, "R5");
    t_relocated(5, 20'h30000, "R5");
    t_high_modes();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule